// File: doc/BRIEF.md
# Cascadable Bidirectional Parity Generator/Checker

This block computes or checks parity over a word assembled from a chain of nine-input parity cells. Each cell after the first consumes eight fresh data bits plus the parity value produced by the stage before it, so a chain of `CELLS` stages covers `8*CELLS+1` data bits. Only the last stage faces the shared parity port. Every earlier stage permanently generates parity and forwards it down the chain.

A single direction input, `rx_sel`, sets what the last stage does. When `rx_sel` is low the stage generates: it enables the port driver and puts its parity bit on `parity_out`, and it holds the active-low error flag `err_n` inactive. When `rx_sel` is high the stage checks: it releases the port, reads `parity_in` and pulls `err_n` low on a mismatch. The tri-state port is split into `parity_out`, `parity_oe` and `parity_in` so that the block can sit inside a larger chip.

When `REG_OUT` is set, one clocked stage with a synchronous active-high reset registers the three outputs.

Top module: `parity_chain`

## Requirements
- R1: With `CELLS`=1 and `rx_sel`=0, `parity_oe` is 1 and `parity_out` is 1 when an even number of the nine data bits are 1, and 0 when an odd number are 1.
- R2: With `rx_sel`=0, `err_n` is 1 for every data word and every `parity_in` level.
- R3: With `rx_sel`=1, `parity_oe` is 0.
- R4: With `CELLS`=1 and `rx_sel`=1, `err_n` is 0 when the count of 1s in the data is even and `parity_in` is 0. It is also 0 when the count is odd and `parity_in` is 1. In every other case it is 1.
- R5: For a chain of `CELLS` stages with `rx_sel`=0, `parity_out` equals the XOR of all `8*CELLS+1` data bits, inverted when `CELLS` is odd, because each stage inverts. Data bit 0 enters the first stage only.
- R6: For a chain with `rx_sel`=1, `err_n` is 0 exactly when `parity_in` differs from the value the chain would drive for the same data with `rx_sel`=0.
- R7: With `REG_OUT`=1, a change on the inputs appears on the outputs after the next rising clock edge and not before.
- R8: With `REG_OUT`=1, a rising edge that samples `rst`=1 sets `parity_oe`=0, `err_n`=1 and `parity_out`=0, whatever the other inputs are.
- R9: With `rx_sel`=0, `parity_in` has no effect on `parity_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| rx_sel | input | 1 | 0: drive the parity port; 1: check the incoming parity |
| data | input | 8*CELLS+1 | Data word spread across the chain |
| parity_in | input | 1 | Level seen on the parity port while it is released |
| parity_out | output | 1 | Generated parity; valid while `parity_oe` is 1 |
| parity_oe | output | 1 | Parity port driver enable |
| err_n | output | 1 | Active-low parity mismatch flag |

## Verification
The case hardest to reach from the ports is a single-bit disagreement deep in the chain. The mismatch must travel through every forwarded link, and an even number of inversions can cancel out. A long chain with random data alone rarely lines up a port level against every parity class. The bench therefore sweeps all 512 patterns of a one-cell instance in generate mode and in check mode with both port levels. It then drives a four-cell instance with random words and toggles `parity_in` against a bench-computed drive value, so that both the error and no-error outcomes appear in every position. Mode flips and a reset in the middle of an active error confirm the one-cycle output timing.

// File: rtl/parity_chain_pkg.sv
package parity_chain_pkg;

    localparam int CELL_W  = 9;
    localparam int FRESH_W = CELL_W - 1;

    typedef struct packed {
        logic par;
        logic oe;
        logic err_n;
    } pc_out_t;

    localparam pc_out_t PC_RESET = '{par: 1'b0, oe: 1'b0, err_n: 1'b1};

endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
    parameter int W = 9
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    localparam int HALF = W / 2;

    generate
        if (W == 1) begin : g_leaf
            assign odd = bits[0];
        end else begin : g_split
            logic lo_odd;
            logic hi_odd;
            parity_tree #(.W(HALF)) u_lo (
                .bits (bits[HALF-1:0]),
                .odd  (lo_odd)
            );
            parity_tree #(.W(W - HALF)) u_hi (
                .bits (bits[W-1:HALF]),
                .odd  (hi_odd)
            );
            assign odd = lo_odd ^ hi_odd;
        end
    endgenerate
endmodule

// File: rtl/parity_cell.sv
module parity_cell
    import parity_chain_pkg::*;
(
    input  logic [CELL_W-1:0] bits,
    input  logic              rx_sel,
    input  logic              pin,
    output pc_out_t           res
);
    logic odd;

    parity_tree #(.W(CELL_W)) u_tree (
        .bits (bits),
        .odd  (odd)
    );

    always_comb begin
        res.par   = ~odd;
        res.oe    = ~rx_sel;
        // mismatch: the incoming bit equals the data's own odd-parity flag
        res.err_n = ~(rx_sel & (odd == pin));
    end
endmodule

// File: rtl/parity_out_stage.sv
module parity_out_stage
    import parity_chain_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  pc_out_t in_res,
    output pc_out_t out_res
);
    generate
        if (REG_OUT) begin : g_reg
            pc_out_t res_d;
            pc_out_t res_q;

            always_comb begin
                res_d = in_res;
                if (rst) begin
                    res_d = PC_RESET;
                end
            end

            always_ff @(posedge clk) begin
                res_q <= res_d;
            end

            assign out_res = res_q;
        end else begin : g_wire
            assign out_res = in_res;
        end
    endgenerate
endmodule

// File: rtl/parity_chain.sv
module parity_chain
    import parity_chain_pkg::*;
#(
    parameter int  CELLS   = 4,
    parameter bit  REG_OUT = 1'b1,
    localparam int DATA_W  = FRESH_W * CELLS + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_sel,
    input  logic [DATA_W-1:0] data,
    input  logic              parity_in,
    output logic              parity_out,
    output logic              parity_oe,
    output logic              err_n
);
    localparam int LINKS = (CELLS > 1) ? CELLS - 1 : 1;

    logic [LINKS-1:0]  link;
    logic [CELL_W-1:0] last_bits;
    pc_out_t           cell_res;
    pc_out_t           stage_res;

    generate
        if (CELLS > 1) begin : g_chain
            for (genvar k = 0; k < CELLS - 1; k++) begin : g_link
                logic [CELL_W-1:0] stage_bits;
                logic              stage_odd;
                if (k == 0) begin : g_first
                    assign stage_bits = data[CELL_W-1:0];
                end else begin : g_next
                    assign stage_bits = {data[FRESH_W*k + FRESH_W -: FRESH_W], link[k-1]};
                end
                parity_tree #(.W(CELL_W)) u_tree (
                    .bits (stage_bits),
                    .odd  (stage_odd)
                );
                // forwarded stages always generate, so they pass on the inverted flag
                assign link[k] = ~stage_odd;
            end
            assign last_bits = {data[DATA_W-1 -: FRESH_W], link[CELLS-2]};
        end else begin : g_single
            assign link      = '0;
            assign last_bits = data[CELL_W-1:0];
        end
    endgenerate

    parity_cell u_last (
        .bits   (last_bits),
        .rx_sel (rx_sel),
        .pin    (parity_in),
        .res    (cell_res)
    );

    parity_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst     (rst),
        .in_res  (cell_res),
        .out_res (stage_res)
    );

    assign parity_out = stage_res.par;
    assign parity_oe  = stage_res.oe;
    assign err_n      = stage_res.err_n;
endmodule

// File: rtl/parity_chain_chk.sv
module parity_chain_chk #(
    parameter int  CELLS   = 4,
    parameter bit  REG_OUT = 1'b1,
    localparam int DATA_W  = 8 * CELLS + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_sel,
    input logic [DATA_W-1:0] data,
    input logic              parity_in,
    input logic              parity_out,
    input logic              parity_oe,
    input logic              err_n
);
    localparam logic INV = CELLS[0];

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    generate
        if (REG_OUT) begin : g_seq
            // R8
            reset_state_chk: assert property (@(posedge clk) disable iff (rst)
                !armed_q |-> (!parity_oe && err_n && !parity_out));
            // R3
            oe_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
                armed_q |-> (parity_oe == !$past(rx_sel)));
            // R2
            err_idle_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
                (armed_q && parity_oe) |-> err_n);
            // R5
            tx_value_chk: assert property (@(posedge clk) disable iff (rst)
                (armed_q && parity_oe) |-> (parity_out == ((^$past(data)) ^ INV)));
            // R6
            rx_error_chk: assert property (@(posedge clk) disable iff (rst)
                (armed_q && !parity_oe) |->
                    (err_n == ($past(parity_in) == ((^$past(data)) ^ INV))));
        end else begin : g_comb
            // R3
            oe_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
                parity_oe == !rx_sel);
            // R2
            err_idle_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
                !rx_sel |-> err_n);
            // R5
            tx_value_chk: assert property (@(posedge clk) disable iff (rst)
                !rx_sel |-> (parity_out == ((^data) ^ INV)));
            // R6
            rx_error_chk: assert property (@(posedge clk) disable iff (rst)
                rx_sel |-> (err_n == (parity_in == ((^data) ^ INV))));
        end
    endgenerate
endmodule

bind parity_chain parity_chain_chk #(.CELLS(CELLS), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_sel     (rx_sel),
    .data       (data),
    .parity_in  (parity_in),
    .parity_out (parity_out),
    .parity_oe  (parity_oe),
    .err_n      (err_n)
);

// File: tb/parity_chain_tb.sv
module parity_chain_tb;
    localparam int C4 = 4;
    localparam int W4 = 8 * C4 + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10ns clk = ~clk;

    logic          rx4 = 1'b0, pin4 = 1'b0;
    logic [W4-1:0] d4  = '0;
    logic          po4, oe4, en4;

    logic          rx1 = 1'b0, pin1 = 1'b0;
    logic [8:0]    d1  = '0;
    logic          po1, oe1, en1;

    int n_cmp = 0;
    int n_bad = 0;

    parity_chain #(.CELLS(C4), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .rx_sel(rx4), .data(d4), .parity_in(pin4),
        .parity_out(po4), .parity_oe(oe4), .err_n(en4)
    );

    parity_chain #(.CELLS(1), .REG_OUT(1'b1)) u_one (
        .clk(clk), .rst(rst), .rx_sel(rx1), .data(d1), .parity_in(pin1),
        .parity_out(po1), .parity_oe(oe1), .err_n(en1)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // value the four-cell chain drives in generate mode: XOR of all bits, flipped for odd CELLS
    function automatic logic drive4(input logic [W4-1:0] d);
        return (^d) ^ C4[0];
    endfunction

    task automatic run4(input logic rx, input logic [W4-1:0] d, input logic pin);
        @(negedge clk);
        rx4 = rx; d4 = d; pin4 = pin;
        @(negedge clk);
        if (!rx) begin
            chk("R5 oe", oe4, 1'b1);
            chk("R5 parity", po4, drive4(d));
            chk("R2 err idle", en4, 1'b1);
        end else begin
            chk("R3 oe off", oe4, 1'b0);
            chk("R6 err", en4, pin == drive4(d));
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog got=running exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W4-1:0] rv;
        logic          keep;

        // R8 reset state, inputs request generate mode
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 reset oe", oe4, 1'b0);
        chk("R8 reset err", en4, 1'b1);
        chk("R8 reset par", po4, 1'b0);
        chk("R8 reset oe one", oe1, 1'b0);
        rst = 1'b0;

        // R1 R2 R3 R4: exhaustive single cell sweep
        for (int v = 0; v < 512; v++) begin
            for (int m = 0; m < 3; m++) begin
                @(negedge clk);
                d1   = v[8:0];
                rx1  = (m != 0);
                pin1 = (m == 0) ? v[0] : (m == 2);
                @(negedge clk);
                if (m == 0) begin
                    chk("R1 oe", oe1, 1'b1);
                    chk("R1 parity", po1, ~(^v[8:0]));
                    chk("R2 err idle", en1, 1'b1);
                end else begin
                    chk("R3 oe off", oe1, 1'b0);
                    chk("R4 err", en1, (^v[8:0]) != pin1);
                end
            end
        end

        // R5 R6 boundary words on the chain
        run4(1'b0, '0, 1'b1);
        run4(1'b0, '1, 1'b0);
        run4(1'b1, '0, drive4('0));
        run4(1'b1, '0, ~drive4('0));
        run4(1'b1, '1, drive4('1));
        run4(1'b1, '1, ~drive4('1));
        for (int b = 0; b < W4; b++) begin
            run4(1'b1, W4'(1) << b, 1'b0);
            run4(1'b1, W4'(1) << b, 1'b1);
        end

        // R5 R6 random words in both modes
        for (int i = 0; i < 2000; i++) begin
            rv = {$urandom, $urandom};
            run4(i[0], rv, $urandom_range(0, 1) == 1);
        end

        // R9 parity_in ignored while generating
        for (int i = 0; i < 40; i++) begin
            rv = {$urandom, $urandom};
            @(negedge clk); rx4 = 1'b0; d4 = rv; pin4 = 1'b0;
            @(negedge clk); keep = po4;
            pin4 = 1'b1;
            @(negedge clk);
            chk("R9 pin ignored", po4, keep);
            chk("R9 pin ignored exp", po4, drive4(rv));
            chk("R2 err idle pin1", en4, 1'b1);
        end

        // R7 latency: mode flip visible only after the next edge
        run4(1'b0, '1, 1'b0);
        @(negedge clk);
        rx4 = 1'b1; pin4 = drive4('1);
        #2ns;
        chk("R7 hold oe", oe4, 1'b1);
        chk("R7 hold err", en4, 1'b1);
        @(negedge clk);
        chk("R7 new oe", oe4, 1'b0);
        chk("R7 new err", en4, 1'b1);
        pin4 = ~drive4('1);
        #2ns;
        chk("R7 hold err2", en4, 1'b1);
        @(negedge clk);
        chk("R7 err after edge", en4, 1'b0);

        // R8 reset during an active error
        rst = 1'b1;
        @(negedge clk);
        chk("R8 mid oe", oe4, 1'b0);
        chk("R8 mid err", en4, 1'b1);
        chk("R8 mid par", po4, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 after reset", en4, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule